// File: doc/BRIEF.md
# Pre/Post Trigger Acquisition Sequencer

This block runs one capture window of a sampling oscilloscope channel. A single-cycle start pulse opens the window. From then on, each packed sample word that the acquisition path writes to a circular channel buffer advances the write address. The sequencer arms trigger detection only after a programmed number of pre-trigger words has been stored. That number is an 8-bit position value times 16 words, and each word carries 8 samples.

Once armed, the sequencer accepts the first trigger event. It captures two results: the buffer address where the host should start reading, which is the oldest word in the window, and the position (0 to 7) of the trigger sample inside its word. It then counts the rest of the buffer as post-trigger data, so that the window fills the buffer exactly once. It flags the end of the window for one cycle and returns to idle.

The trigger comparator, the memory path and the host side sit outside this block. They connect through the start, word-write, trigger and result ports.

Top module: `acq_window_seq`

## Requirements
- R1: After reset the block is idle: busy, armed, post-trigger and end-window outputs are 0, and the write address, read-start address and trigger offset are 0.
- R2: Busy rises in the cycle after a start pulse and stays high through the end-window cycle. It is 0 in idle.
- R3: The position input is sampled only on the start pulse. Armed rises in the cycle after the (position×16)-th word write that follows the start. A position of 0 arms in the cycle after the start itself.
- R4: A trigger counts only when the trigger input and the word-write input are high together while armed. A trigger at any other time changes neither the flags nor the captured results.
- R5: Post-trigger rises and armed falls in the cycle after an accepted trigger. Armed and post-trigger are never high together. Post-trigger falls when end-window rises.
- R6: The post-trigger phase lasts depth − position×16 word writes, counting the trigger word. End-window is high for exactly one cycle after the last of these writes, and the block is idle in the following cycle.
- R7: The write address goes to 0 on start. It then steps by 1, modulo the buffer depth (2^ADDR_W), for each word write in the pre-trigger, armed and post-trigger phases. Cycles without a word write leave it unchanged.
- R8: On an accepted trigger, the read-start output becomes (trigger word's address − position×16) modulo depth, and the offset output takes the trigger lane input. Both hold until the next start, which clears them to 0.
- R9: A start pulse while busy abandons the current window and begins a new one from address 0, using the newly sampled position.
- R10: Word writes while idle are ignored: the write address does not change.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous reset, active low |
| start_i | input | 1 | One-cycle pulse that opens a window |
| pos_i | input | POS_W (8) | Pre-trigger amount in 16-word blocks |
| word_we_i | input | 1 | A packed word is written this cycle |
| trig_hit_i | input | 1 | Trigger detected in the word written this cycle |
| trig_lane_i | input | LANE_W (3) | Sample position of the trigger within that word |
| wr_addr_o | output | ADDR_W (12) | Buffer address for this cycle's word |
| acq_busy_o | output | 1 | Window in progress |
| armed_o | output | 1 | Trigger search enabled |
| post_o | output | 1 | Post-trigger phase |
| end_win_o | output | 1 | One-cycle end-of-window flag |
| rd_start_o | output | ADDR_W (12) | First address the host should read |
| trig_ofs_o | output | LANE_W (3) | Trigger sample offset within its word |

## Verification
All flags and the write address come from registers updated on the edge that takes in a start, a write or a trigger, so each change is visible one cycle after its stimulus. End-window follows the final post-trigger write by one cycle, and idle follows one cycle later. The bench drives inputs just after a rising edge and reads outputs just after the next one, so every check falls in the first cycle where the new value is due. Windows are placed at exact word counts: one write short of arming, and one write short of the end, to pin down each boundary.

// File: rtl/acq_seq_pkg.sv
// Shared types for the acquisition window sequencer.
// Assumes: nothing beyond IEEE 1800-2017 enums.
package acq_seq_pkg;
    typedef enum logic [2:0] {
        ST_IDLE  = 3'd0,
        ST_PRE   = 3'd1,
        ST_ARMED = 3'd2,
        ST_POST  = 3'd3,
        ST_DONE  = 3'd4
    } acq_state_e;
endpackage

// File: rtl/acq_seq_fsm.sv
// Phase controller: decides when the window arms, when a trigger is taken
// and when the post-trigger count has run out.
// Assumes: 2^ADDR_W exceeds (2^POS_W - 1) * 2^BLK_SHIFT by at least 2, so
// the post-trigger remainder is never below 1.
module acq_seq_fsm
    import acq_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int POS_W     = 8,
    parameter int BLK_SHIFT = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              word_we_i,
    input  logic              trig_hit_i,
    input  logic [ADDR_W:0]   phase_cnt_i,
    output acq_state_e        state_o,
    output logic [ADDR_W:0]   pre_words_o,
    output logic              phase_clr_o,
    output logic              phase_en_o,
    output logic              addr_en_o,
    output logic              trig_take_o
);
    timeunit 1ns; timeprecision 1ps;

    localparam int CNT_W = ADDR_W + 1;
    localparam logic [CNT_W-1:0] DEPTH_C = CNT_W'(2 ** ADDR_W);

    acq_state_e        st_q, st_d;
    logic [POS_W-1:0]  pos_q;
    logic [CNT_W-1:0]  post_rest;
    logic [CNT_W-1:0]  phase_next;

    // Hold the position value sampled at the start pulse.
    always_ff @(posedge clk) begin
        if (!rst_n)       pos_q <= '0;
        else if (start_i) pos_q <= pos_i;
    end

    // Derive the phase lengths from the held position.
    always_comb begin
        pre_words_o = CNT_W'({pos_q, {BLK_SHIFT{1'b0}}});
        post_rest   = DEPTH_C - pre_words_o - CNT_W'(1);
        phase_next  = phase_cnt_i + CNT_W'(1);
    end

    // Qualify writes and triggers by phase; start has priority over all.
    always_comb begin
        trig_take_o = (st_q == ST_ARMED) && trig_hit_i && word_we_i && !start_i;
        phase_clr_o = start_i || trig_take_o;
        phase_en_o  = word_we_i && !start_i && ((st_q == ST_PRE) || (st_q == ST_POST));
        addr_en_o   = word_we_i && !start_i &&
                      ((st_q == ST_PRE) || (st_q == ST_ARMED) || (st_q == ST_POST));
    end

    // Next-state selection.
    always_comb begin
        st_d = st_q;
        if (start_i) begin
            st_d = (pos_i == '0) ? ST_ARMED : ST_PRE;
        end else begin
            case (st_q)
                ST_PRE:   if (word_we_i && phase_next == pre_words_o) st_d = ST_ARMED;
                ST_ARMED: if (trig_take_o) st_d = ST_POST;
                ST_POST:  if (word_we_i && phase_next == post_rest) st_d = ST_DONE;
                ST_DONE:  st_d = ST_IDLE;
                default:  st_d = ST_IDLE;
            endcase
        end
    end

    // State register.
    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    assign state_o = st_q;

    // R5
    post_from_armed_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(st_q == ST_POST) |-> $past(st_q == ST_ARMED));

    // R6
    done_one_cycle_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_DONE) && !start_i |=> (st_q == ST_IDLE));

    // R3
    arm_after_pre_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == ST_ARMED) && $past(st_q == ST_PRE) |->
            ($past(phase_cnt_i) + CNT_W'(1) == pre_words_o));
endmodule

// File: rtl/acq_word_track.sv
// Word tracking: the circular write address and the per-phase word count.
// Assumes: the buffer depth is a power of two, so the address wraps on its own.
module acq_word_track #(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              phase_clr_i,
    input  logic              phase_en_i,
    input  logic              addr_en_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic [ADDR_W:0]   phase_cnt_o
);
    timeunit 1ns; timeprecision 1ps;

    logic [ADDR_W-1:0] addr_q;
    logic [ADDR_W:0]   cnt_q;

    // Circular write address, restarted on each window.
    always_ff @(posedge clk) begin
        if (!rst_n)         addr_q <= '0;
        else if (start_i)   addr_q <= '0;
        else if (addr_en_i) addr_q <= addr_q + ADDR_W'(1);
    end

    // Words written in the current counted phase.
    always_ff @(posedge clk) begin
        if (!rst_n)           cnt_q <= '0;
        else if (phase_clr_i) cnt_q <= '0;
        else if (phase_en_i)  cnt_q <= cnt_q + (ADDR_W+1)'(1);
    end

    assign wr_addr_o   = addr_q;
    assign phase_cnt_o = cnt_q;

    // R7
    addr_step_chk: assert property (@(posedge clk) disable iff (!rst_n)
        addr_en_i && !start_i |=> wr_addr_o == $past(wr_addr_o) + ADDR_W'(1));

    // R10
    addr_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en_i && !start_i |=> $stable(wr_addr_o));
endmodule

// File: rtl/acq_trig_latch.sv
// Result capture: read-start address and in-word trigger offset.
// Assumes: the trigger qualifier marks the word written at wr_addr_i this cycle.
module acq_trig_latch #(
    parameter int ADDR_W = 12,
    parameter int LANE_W = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic              trig_take_i,
    input  logic [ADDR_W-1:0] wr_addr_i,
    input  logic [ADDR_W:0]   pre_words_i,
    input  logic [LANE_W-1:0] lane_i,
    output logic [ADDR_W-1:0] rd_start_o,
    output logic [LANE_W-1:0] trig_ofs_o
);
    timeunit 1ns; timeprecision 1ps;

    logic [ADDR_W-1:0] rd_q;
    logic [LANE_W-1:0] ofs_q;

    // Capture results on the accepted trigger; clear on each start.
    always_ff @(posedge clk) begin
        if (!rst_n || start_i) begin
            rd_q  <= '0;
            ofs_q <= '0;
        end else if (trig_take_i) begin
            rd_q  <= ADDR_W'({1'b0, wr_addr_i} - pre_words_i);
            ofs_q <= lane_i;
        end
    end

    assign rd_start_o = rd_q;
    assign trig_ofs_o = ofs_q;

    // R8
    result_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !start_i && !trig_take_i |=> $stable(rd_start_o) && $stable(trig_ofs_o));
endmodule

// File: rtl/acq_window_seq.sv
// Top of the acquisition window sequencer: wires the phase controller, the
// word tracker and the result capture, and decodes the phase flags.
// Assumes: start_i is a one-cycle pulse; trig_hit_i refers to the word
// written in the same cycle.
module acq_window_seq
    import acq_seq_pkg::*;
#(
    parameter int ADDR_W    = 12,
    parameter int POS_W     = 8,
    parameter int BLK_SHIFT = 4,
    parameter int LANE_W    = 3
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              start_i,
    input  logic [POS_W-1:0]  pos_i,
    input  logic              word_we_i,
    input  logic              trig_hit_i,
    input  logic [LANE_W-1:0] trig_lane_i,
    output logic [ADDR_W-1:0] wr_addr_o,
    output logic              acq_busy_o,
    output logic              armed_o,
    output logic              post_o,
    output logic              end_win_o,
    output logic [ADDR_W-1:0] rd_start_o,
    output logic [LANE_W-1:0] trig_ofs_o
);
    timeunit 1ns; timeprecision 1ps;

    acq_state_e      state;
    logic [ADDR_W:0] pre_words;
    logic [ADDR_W:0] phase_cnt;
    logic            phase_clr, phase_en, addr_en, trig_take;

    acq_seq_fsm #(.ADDR_W(ADDR_W), .POS_W(POS_W), .BLK_SHIFT(BLK_SHIFT)) u_fsm (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pos_i(pos_i),
        .word_we_i(word_we_i), .trig_hit_i(trig_hit_i), .phase_cnt_i(phase_cnt),
        .state_o(state), .pre_words_o(pre_words), .phase_clr_o(phase_clr),
        .phase_en_o(phase_en), .addr_en_o(addr_en), .trig_take_o(trig_take)
    );

    acq_word_track #(.ADDR_W(ADDR_W)) u_track (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .phase_clr_i(phase_clr),
        .phase_en_i(phase_en), .addr_en_i(addr_en),
        .wr_addr_o(wr_addr_o), .phase_cnt_o(phase_cnt)
    );

    acq_trig_latch #(.ADDR_W(ADDR_W), .LANE_W(LANE_W)) u_latch (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .trig_take_i(trig_take),
        .wr_addr_i(wr_addr_o), .pre_words_i(pre_words), .lane_i(trig_lane_i),
        .rd_start_o(rd_start_o), .trig_ofs_o(trig_ofs_o)
    );

    // Decode phase flags from the registered state.
    always_comb begin
        acq_busy_o = (state != ST_IDLE);
        armed_o    = (state == ST_ARMED);
        post_o     = (state == ST_POST);
        end_win_o  = (state == ST_DONE);
    end

    // R5
    flags_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !(armed_o && post_o));

    // R2
    busy_covers_flags_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (armed_o || post_o || end_win_o) |-> acq_busy_o);
endmodule

// File: tb/acq_window_seq_test.sv
// Directed bench for the acquisition window sequencer, 250 MHz clock.
module acq_window_seq_test;
    timeunit 1ns; timeprecision 1ps;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        start_i = 1'b0;
    logic [7:0]  pos_i = '0;
    logic        word_we_i = 1'b0;
    logic        trig_hit_i = 1'b0;
    logic [2:0]  trig_lane_i = '0;
    logic [11:0] wr_addr_o, rd_start_o;
    logic        acq_busy_o, armed_o, post_o, end_win_o;
    logic [2:0]  trig_ofs_o;

    int total = 0;
    int bad = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    acq_window_seq uut (
        .clk(clk), .rst_n(rst_n), .start_i(start_i), .pos_i(pos_i),
        .word_we_i(word_we_i), .trig_hit_i(trig_hit_i), .trig_lane_i(trig_lane_i),
        .wr_addr_o(wr_addr_o), .acq_busy_o(acq_busy_o), .armed_o(armed_o),
        .post_o(post_o), .end_win_o(end_win_o), .rd_start_o(rd_start_o),
        .trig_ofs_o(trig_ofs_o)
    );

    task automatic check(input string req, input string what, input int act, input int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s %s: actual=%0d expected=%0d", req, what, act, exp);
        end
    endtask

    // Drive one cycle of inputs; outputs are readable on return.
    task automatic step(input logic s, input logic we, input logic hit, input logic [2:0] lane);
        start_i = s; word_we_i = we; trig_hit_i = hit; trig_lane_i = lane;
        @(posedge clk); #1;
        start_i = 1'b0; word_we_i = 1'b0; trig_hit_i = 1'b0;
    endtask

    task automatic writes(input int n);
        for (int i = 0; i < n; i++) step(1'b0, 1'b1, 1'b0, 3'd0);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (5) @(posedge clk);
        #1 rst_n = 1'b1;
        check("R1", "busy", acq_busy_o, 0);
        check("R1", "armed", armed_o, 0);
        check("R1", "post", post_o, 0);
        check("R1", "end", end_win_o, 0);
        check("R1", "addr", wr_addr_o, 0);
        check("R1", "rd_start", rd_start_o, 0);
        check("R1", "ofs", trig_ofs_o, 0);
    endtask

    task automatic t_idle_writes();
        for (int i = 0; i < 3; i++) step(1'b0, 1'b1, 1'b1, 3'd3);
        check("R10", "addr idle", wr_addr_o, 0);
        check("R10", "busy idle", acq_busy_o, 0);
        check("R4", "post idle trig", post_o, 0);
        check("R4", "rd idle trig", rd_start_o, 0);
    endtask

    // Position 2: 32 pre words, trigger at address 37, wraps at the end.
    task automatic t_full_window();
        pos_i = 8'd2;
        step(1'b1, 1'b0, 1'b0, 3'd0);
        pos_i = 8'd7;
        check("R2", "busy after start", acq_busy_o, 1);
        check("R3", "armed at start", armed_o, 0);
        check("R7", "addr at start", wr_addr_o, 0);
        writes(31);
        check("R3", "armed one short", armed_o, 0);
        check("R7", "addr 31", wr_addr_o, 31);
        writes(1);
        check("R3", "armed at 32", armed_o, 1);
        writes(5);
        check("R7", "addr 37", wr_addr_o, 37);
        step(1'b0, 1'b1, 1'b1, 3'd5);
        check("R5", "post rises", post_o, 1);
        check("R5", "armed falls", armed_o, 0);
        check("R8", "rd_start", rd_start_o, 5);
        check("R8", "ofs", trig_ofs_o, 5);
        writes(4062);
        check("R6", "end one short", end_win_o, 0);
        check("R5", "post held", post_o, 1);
        writes(1);
        check("R6", "end high", end_win_o, 1);
        check("R5", "post falls", post_o, 0);
        check("R2", "busy at end", acq_busy_o, 1);
        check("R7", "addr wrapped", wr_addr_o, 5);
        step(1'b0, 1'b0, 1'b0, 3'd0);
        check("R6", "end one cycle", end_win_o, 0);
        check("R2", "busy idle", acq_busy_o, 0);
        check("R8", "rd held", rd_start_o, 5);
        step(1'b0, 1'b1, 1'b0, 3'd0);
        check("R10", "addr after window", wr_addr_o, 5);
    endtask

    // Position 1 with an early trigger, then a restart while armed.
    task automatic t_ignore_and_restart();
        pos_i = 8'd1;
        step(1'b1, 1'b0, 1'b0, 3'd0);
        check("R8", "rd cleared", rd_start_o, 0);
        check("R8", "ofs cleared", trig_ofs_o, 0);
        writes(3);
        step(1'b0, 1'b1, 1'b1, 3'd2);
        check("R4", "pre trig post", post_o, 0);
        check("R4", "pre trig armed", armed_o, 0);
        check("R4", "pre trig rd", rd_start_o, 0);
        writes(12);
        check("R3", "armed at 16", armed_o, 1);
        check("R7", "addr 16", wr_addr_o, 16);
        step(1'b0, 1'b0, 1'b1, 3'd6);
        check("R4", "hit without write", post_o, 0);
        check("R4", "still armed", armed_o, 1);
        step(1'b0, 1'b0, 1'b0, 3'd0);
        check("R7", "gap holds", wr_addr_o, 16);
        pos_i = 8'd3;
        step(1'b1, 1'b1, 1'b0, 3'd0);
        check("R9", "restart armed", armed_o, 0);
        check("R9", "restart busy", acq_busy_o, 1);
        check("R9", "restart addr", wr_addr_o, 0);
        writes(47);
        check("R9", "new pos one short", armed_o, 0);
        writes(1);
        check("R9", "new pos armed", armed_o, 1);
        check("R7", "addr 48", wr_addr_o, 48);
    endtask

    // Position 0: arms at once, post phase spans 4095 more writes.
    task automatic t_zero_pos();
        pos_i = 8'd0;
        step(1'b1, 1'b0, 1'b0, 3'd0);
        check("R3", "pos0 armed", armed_o, 1);
        writes(3);
        step(1'b0, 1'b1, 1'b1, 3'd7);
        check("R8", "pos0 rd", rd_start_o, 3);
        check("R8", "pos0 ofs", trig_ofs_o, 7);
        writes(4094);
        check("R6", "pos0 end short", end_win_o, 0);
        writes(1);
        check("R6", "pos0 end", end_win_o, 1);
        check("R7", "pos0 addr", wr_addr_o, 3);
        step(1'b0, 1'b0, 1'b0, 3'd0);
        check("R6", "pos0 idle", acq_busy_o, 0);
    endtask

    initial begin
        t_reset();
        t_idle_writes();
        t_full_window();
        t_ignore_and_restart();
        t_zero_pos();
        finished = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (200000) @(posedge clk);
        if (!finished) begin
            total++;
            bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end
endmodule